// File: doc/BRIEF.md
# Dual-Mode Display Identification Memory

This block holds a 128-byte identification table and, from power-up, streams it onto a shared open-drain data line in a transmit-only fashion. Each rising edge of a dedicated transmit clock moves the stream on by one bit. Before any data appears, the block runs a nine-clock start-up phase. During that phase it watches the level on the data line to pick the byte where streaming begins. After that, every byte goes out most significant bit first and is followed by a released ninth slot. The address runs through the whole table and wraps without a pause.

A second, bidirectional-mode clock normally rests high. The first high-to-low transition seen on it, after synchronization, moves the block into bidirectional mode for good. Only a power-up reset brings it back to transmit-only mode. In bidirectional mode the block stops driving the line and freezes its stream counters. It reports the mode and flags a write-inhibit condition whenever the transmit clock is low. The serial read/write protocol of that mode is handled elsewhere.

The table is filled through a backdoor load port with a valid/ready handshake. Ready is held high at all times, so there is never back-pressure: a byte is written on every clock cycle in which valid is high. Reset does not clear the table. Both clocks pass through two-stage synchronizers and are edge-detected on the system clock. The data-line input is sampled on the detected transmit-clock rising edge.

Top module: `dispid_mem`

## Requirements
- R1: While reset is asserted and right after it, the line is released (`sda_hiz_o`=1, `sda_drive_low_o`=0), `bidir_mode_o`=0, `write_inhibit_o`=0.
- R2: During the first eight transmit-clock rising edges after reset, and until the ninth, the block never drives the line low and keeps `sda_hiz_o`=1.
- R3: The start address is set by the data-line level sampled on the eighth start-up edge: high gives 0x7F, low gives 0x00. If the earlier levels differ, only the eighth one counts.
- R4: The ninth start-up edge presents bit 7 of the start byte. Each later edge presents the next lower bit. For a data slot, `sda_drive_low_o`=1 exactly when the bit is 0, and `sda_hiz_o`=0.
- R5: The slot after bit 0 of each byte is released (`sda_hiz_o`=1, `sda_drive_low_o`=0). The edge after that slot presents bit 7 of the next byte.
- R6: The byte address increments by one per byte and wraps from 0x7F to 0x00 with no idle slot.
- R7: A synchronized high-to-low transition on `bclk_i` sets `bidir_mode_o`. The flag then stays set whatever the clocks do, until reset.
- R8: In bidirectional mode `sda_drive_low_o`=0 and `sda_hiz_o`=1, whatever the transmit clock does.
- R9: `write_inhibit_o` is 1 only in bidirectional mode while the synchronized transmit clock is low. It is 0 in transmit-only mode.
- R10: `load_ready_o` is always 1. A cycle with `load_valid_i`=1 writes `load_data_i` at `load_addr_i`, and the streamed data reflects the latest write to each address.
- R11: `sda_drive_low_o` and `sda_hiz_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| txclk_i | input | 1 | Transmit-only clock, asynchronous |
| bclk_i | input | 1 | Bidirectional-mode clock, asynchronous, rests high |
| sda_i | input | 1 | Data-line level as seen on the wire |
| sda_drive_low_o | output | 1 | Pull the data line low |
| sda_hiz_o | output | 1 | Data line released as a don't-care slot |
| bidir_mode_o | output | 1 | Block has left transmit-only mode |
| write_inhibit_o | output | 1 | Writes inhibited (bidirectional mode, transmit clock low) |
| load_valid_i | input | 1 | Backdoor write request |
| load_ready_o | output | 1 | Backdoor write accepted (always high) |
| load_addr_i | input | 7 | Backdoor write address |
| load_data_i | input | 8 | Backdoor write data |

## Verification
The bench streams the full table with every bit compared against a model that is filled through the load port. It does this once from 0x00 for 130 bytes, crossing the wrap, and again from 0x7F, where the wrap comes on the second byte. A design that wraps late, inserts a gap slot, or shifts LSB first shows up as data miscompares right at the boundary. Start-up patterns with mixed levels expose a design that latches the first sample rather than the eighth, or that counts eight start-up clocks instead of nine and so emits one bit early. The mode switch is driven in the middle of a byte to catch a design that keeps driving the line, that drops the mode when the clock returns high, or that raises write-inhibit in transmit-only mode.

// File: rtl/dispid_pkg.sv
`timescale 1ns/1ps
package dispid_pkg;
  typedef enum logic {
    PH_INIT   = 1'b0,
    PH_STREAM = 1'b1
  } phase_e;
endpackage

// File: rtl/dispid_edge_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer followed by a single-edge detector.
module dispid_edge_sync #(
  parameter int STAGES    = 2,
  parameter bit EDGE_FALL = 1'b0,
  parameter bit IDLE      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE}};
      last  <= IDLE;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      last  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];

  generate
    if (EDGE_FALL) begin : g_fall
      assign edge_o = last & ~level_o;
    end else begin : g_rise
      assign edge_o = ~last & level_o;
    end
  endgenerate
endmodule

// File: rtl/dispid_array.sv
`timescale 1ns/1ps
// Identification table with a backdoor write port and an asynchronous read.
module dispid_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ld_valid_i,
  output logic          ld_ready_o,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign ld_ready_o = 1'b1;

  always_ff @(posedge clk) begin
    if (ld_valid_i) mem[ld_addr_i] <= ld_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/dispid_tx_seq.sv
`timescale 1ns/1ps
// Start-up counter, start-address choice, bit/byte sequencing and line drive.
module dispid_tx_seq
  import dispid_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_rise_i,
  input  logic          sda_i,
  input  logic          freeze_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          drive_low_o,
  output logic          hiz_o
);
  localparam int SLOTS = DW + 1;
  localparam int IW    = $clog2(SLOTS + 1);
  localparam logic [AW-1:0] ADDR_MAX = '1;
  localparam logic [IW-1:0] LAST_CAP = IW'(SLOTS - 2);
  localparam logic [IW-1:0] GAP_IDX  = IW'(DW);

  phase_e        phase;
  logic [IW-1:0] init_cnt;
  logic          start_hi;
  logic [IW-1:0] bit_idx;
  logic [AW-1:0] addr;
  logic          step;

  assign step = tx_rise_i && !freeze_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_INIT;
      init_cnt <= '0;
      start_hi <= 1'b0;
      bit_idx  <= '0;
      addr     <= '0;
    end else if (step) begin
      if (phase == PH_INIT) begin
        if (init_cnt <= LAST_CAP) begin
          start_hi <= sda_i;
          init_cnt <= init_cnt + 1'b1;
        end else begin
          phase   <= PH_STREAM;
          addr    <= start_hi ? ADDR_MAX : '0;
          bit_idx <= '0;
        end
      end else begin
        if (bit_idx == GAP_IDX) begin
          bit_idx <= '0;
          addr    <= addr + 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  logic          data_slot;
  logic [DW-1:0] shifted;

  assign rd_addr_o   = addr;
  assign shifted     = rd_data_i << bit_idx;
  assign data_slot   = (phase == PH_STREAM) && (bit_idx != GAP_IDX) && !freeze_i;
  assign drive_low_o = data_slot & ~shifted[DW-1];
  assign hiz_o       = ~data_slot;

  AST_LINE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low_o && hiz_o)); // R11
  AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT) |-> !drive_low_o); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_STREAM && bit_idx == GAP_IDX && addr == ADDR_MAX) |=> (addr == '0)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STREAM && !step) |=> $stable(addr)); // R6
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> (hiz_o && !drive_low_o)); // R8
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> ($stable(bit_idx) && $stable(addr))); // R8
endmodule

// File: rtl/dispid_mode_ctrl.sv
`timescale 1ns/1ps
// One-way mode latch and write-inhibit qualifier.
module dispid_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_fall_i,
  input  logic bclk_level_i,
  input  logic txclk_level_i,
  output logic bidir_o,
  output logic inhibit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bidir_o <= 1'b0;
    else if (bclk_fall_i) bidir_o <= 1'b1;
  end

  assign inhibit_o = bidir_o & ~txclk_level_i;

  AST_FALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall_i |-> !bclk_level_i); // R7
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_o |=> bidir_o); // R7
  AST_MODE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall_i |=> bidir_o); // R7
endmodule

// File: rtl/dispid_mem.sv
`timescale 1ns/1ps
module dispid_mem #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txclk_i,
  input  logic          bclk_i,
  input  logic          sda_i,
  output logic          sda_drive_low_o,
  output logic          sda_hiz_o,
  output logic          bidir_mode_o,
  output logic          write_inhibit_o,
  input  logic          load_valid_i,
  output logic          load_ready_o,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i
);
  logic          tx_level, tx_rise;
  logic          b_level, b_fall;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  dispid_edge_sync #(.STAGES(SYNC_STAGES), .EDGE_FALL(1'b0), .IDLE(1'b0)) i_tx_sync (
    .clk(clk), .rst_n(rst_n), .async_i(txclk_i), .level_o(tx_level), .edge_o(tx_rise)
  );

  dispid_edge_sync #(.STAGES(SYNC_STAGES), .EDGE_FALL(1'b1), .IDLE(1'b1)) i_b_sync (
    .clk(clk), .rst_n(rst_n), .async_i(bclk_i), .level_o(b_level), .edge_o(b_fall)
  );

  dispid_mode_ctrl i_mode (
    .clk(clk), .rst_n(rst_n), .bclk_fall_i(b_fall), .bclk_level_i(b_level),
    .txclk_level_i(tx_level), .bidir_o(bidir_mode_o), .inhibit_o(write_inhibit_o)
  );

  dispid_array #(.AW(AW), .DW(DW)) i_array (
    .clk(clk), .ld_valid_i(load_valid_i), .ld_ready_o(load_ready_o),
    .ld_addr_i(load_addr_i), .ld_data_i(load_data_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  dispid_tx_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk(clk), .rst_n(rst_n), .tx_rise_i(tx_rise), .sda_i(sda_i),
    .freeze_i(bidir_mode_o), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .drive_low_o(sda_drive_low_o), .hiz_o(sda_hiz_o)
  );

  AST_INHIBIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    write_inhibit_o |-> bidir_mode_o); // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_i |-> load_ready_o); // R10
endmodule

// File: tb/test_dispid_mem.sv
`timescale 1ns/1ps
module test_dispid_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txclk = 1'b0, bclk = 1'b1, sda = 1'b1;
  logic       dl, hz, bidir, inh;
  logic       ld_valid = 1'b0, ld_ready;
  logic [6:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  int vectors = 0, miscmp = 0;
  logic [7:0] model [128];
  logic s_dl, s_hz, s_inh;

  always #5 clk = ~clk;

  dispid_mem i_dispid_mem (
    .clk(clk), .rst_n(rst_n), .txclk_i(txclk), .bclk_i(bclk), .sda_i(sda),
    .sda_drive_low_o(dl), .sda_hiz_o(hz), .bidir_mode_o(bidir), .write_inhibit_o(inh),
    .load_valid_i(ld_valid), .load_ready_o(ld_ready), .load_addr_i(ld_addr), .load_data_i(ld_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    txclk = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    s_dl = dl; s_hz = hz; s_inh = inh;
    txclk = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; txclk = 1'b0; bclk = 1'b1; sda = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hz == 1'b1 && dl == 1'b0, "R1 line", {dl, hz}, 2'b01);
    chk(bidir == 1'b0 && inh == 1'b0, "R1 mode", {bidir, inh}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input int a, input logic [7:0] d);
    ld_valid = 1'b1; ld_addr = 7'(a); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    model[a] = d;
  endtask

  // lv[i] is the line level for start-up edge i+1; returns chosen start
  task automatic startup(input logic [7:0] lv, output int start);
    for (int i = 0; i < 8; i++) begin
      sda = lv[i];
      tick();
      chk(s_hz == 1'b1 && s_dl == 1'b0, "R2 startup silent", {s_dl, s_hz}, 2'b01);
    end
    sda = 1'b1;
    start = lv[7] ? 127 : 0;
  endtask

  task automatic stream(input int start, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      int a;
      a = (start + k) % 128;
      for (int b = 0; b < 9; b++) begin
        tick();
        if (b < 8) begin
          logic ebit;
          string tag;
          ebit = model[a][7 - b];
          tag = (k == 0) ? "R3 start byte" : ((a == 0) ? "R6 wrap byte" : "R4 data bit");
          chk(s_dl == ~ebit && s_hz == 1'b0, tag, {a, s_dl, s_hz}, {a, ~ebit, 1'b0});
        end else begin
          chk(s_hz == 1'b1 && s_dl == 1'b0, "R5 ninth slot", {s_dl, s_hz}, 2'b01);
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    int st;
    do_reset();
    chk(ld_ready == 1'b1, "R10 ready", ld_ready, 1);
    for (int a = 0; a < 128; a++) load(a, pat(a));

    // start high: 0x7F then wrap to 0x00
    startup(8'hFF, st);
    stream(st, 3);
    chk(inh == 1'b0, "R9 no inhibit in transmit-only", inh, 0);

    // partial byte, then switch modes mid-byte
    for (int b = 0; b < 3; b++) tick();
    bclk = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(bidir == 1'b1, "R7 enter bidir", bidir, 1);
    chk(hz == 1'b1 && dl == 1'b0, "R8 line released", {dl, hz}, 2'b01);
    chk(inh == 1'b1, "R9 inhibit with txclk low", inh, 1);
    for (int t = 0; t < 12; t++) begin
      tick();
      chk(s_hz == 1'b1 && s_dl == 1'b0, "R8 quiet under txclk", {s_dl, s_hz}, 2'b01);
      chk(s_inh == 1'b0, "R9 inhibit off with txclk high", s_inh, 0);
    end
    bclk = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(bidir == 1'b1, "R7 sticky after bclk high", bidir, 1);
    bclk = 1'b0;
    repeat (8) @(posedge clk);
    bclk = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(bidir == 1'b1, "R7 sticky after second edge", bidir, 1);

    // reset returns to transmit-only; mixed levels, eighth is low -> 0x00
    do_reset();
    chk(bidir == 1'b0, "R7 reset clears mode", bidir, 0);
    startup(8'b0101_0101, st);
    chk(st == 0, "R3 eighth level low", st, 0);
    stream(st, 130);

    // overwrite entries, mixed levels with eighth high -> 0x7F
    load(127, 8'h5A);
    load(0, 8'hC3);
    load(1, 8'h00);
    do_reset();
    startup(8'b1010_1010, st);
    stream(st, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule